// File: doc/BRIEF.md
# Double-Banked Configuration Switch

This block keeps two full copies of a small per-port configuration set: a frame-control word plus one configuration word per port. The words hold channel enables, payload offset and a flag for sample intervals longer than one frame. Only one copy, the active bank, drives the datapath. A host writes either copy through a single write port. Each write carries a device address and a register address. The register address names the bank and the register inside it.

To move the datapath onto the other copy, the host first fills the idle bank. It then writes that bank's frame-control word. The write only arms a request. The bank index flips at a later frame-boundary strobe, so every port changes configuration at the same instant. When any active port has a sample interval spanning several frames, the flip also waits for the stream-synchronization strobe, so the change lands on a point where every stream realigns. Device address 15 acts as an alias that every device accepts, so one command can arm all devices on a bus together.

Top module: `bank_switch_ctrl`

## Requirements
- R1: After reset, bank 0 is active, no switch is pending, and both banks hold the frame-control default 0x10 and all-zero port words.
- R2: The register address is 5 bits wide. Bit 4 selects the bank. Bits 3:0 select the register: 0 is frame control, 1 to NUM_PORTS is the word of port index minus one, and any other value is ignored.
- R3: A write is accepted when its device address equals DEV_ID (default 3) or the alias 15. Any other device address leaves all state unchanged.
- R4: An accepted write to the active bank appears on the configuration outputs in the cycle after the write.
- R5: An accepted write to a non-frame-control register of the inactive bank does not change the configuration outputs.
- R6: An accepted write to the inactive bank's frame-control register raises switch_pending in the next cycle and leaves active_bank unchanged.
- R7: A pending switch flips active_bank and clears switch_pending at the first clock edge after the trigger cycle where frame_edge is high. A frame_edge in the trigger cycle itself does not apply it. Without frame_edge the request is held.
- R8: A write to the active bank's frame-control register updates that register and does not request a switch.
- R9: If bit 2 (the multi-frame flag) of any active-bank port word is set, a pending switch applies only on a frame_edge that coincides with ssp.
- R10: ssp without frame_edge never applies a pending switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_dev | input | DEV_W (4) | Device address of the command |
| wr_addr | input | ADDR_W (5) | Bank select and register index |
| wr_data | input | DATA_W (8) | Write data |
| frame_edge | input | 1 | Frame-boundary strobe |
| ssp | input | 1 | Stream-synchronization-point strobe |
| active_bank | output | 1 | Index of the bank driving the datapath |
| switch_pending | output | 1 | A bank switch is armed and not yet applied |
| frame_ctl_o | output | DATA_W (8) | Active bank frame-control word |
| port_cfg_o | output | NUM_PORTS*DATA_W (16) | Active bank port words, port 0 in the low bits |

## Verification
The bench raises frame_edge during the very cycle of the trigger write. A design that applied the switch at write time would flip banks there instead of one boundary later. It writes into the idle bank and to unmatched devices and register indexes, which would expose leakage into the outputs. It also rewrites the active frame-control word, which a careless trigger decode would treat as a switch request. With a multi-frame port active, it offers a boundary without ssp and an ssp without a boundary. A design that ignored the synchronization rule would flip early, and one that keyed on ssp alone would flip off-frame.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
   typedef enum logic {
      BANK_A = 1'b0,
      BANK_B = 1'b1
   } bank_t;

   localparam int ALIAS_DEV = 15;
endpackage

// File: rtl/bsw_decode.sv
module bsw_decode #(
   parameter int DEV_W     = 4,
   parameter int ADDR_W    = 5,
   parameter int NUM_PORTS = 2,
   parameter int DEV_ID    = 3,
   parameter int ALIAS_ID  = bsw_pkg::ALIAS_DEV
) (
   input  logic                 wr_en,
   input  logic [DEV_W-1:0]     wr_dev,
   input  logic [ADDR_W-1:0]    wr_addr,
   output logic                 hit,
   output bsw_pkg::bank_t       wbank,
   output logic                 fc_sel,
   output logic [NUM_PORTS-1:0] port_sel
);
   localparam int IDX_W = ADDR_W - 1;

   logic [IDX_W-1:0] idx;
   logic             dev_match;

   assign idx       = wr_addr[IDX_W-1:0];
   assign wbank     = bsw_pkg::bank_t'(wr_addr[ADDR_W-1]);
   assign dev_match = (wr_dev == DEV_W'(DEV_ID)) || (wr_dev == DEV_W'(ALIAS_ID));
   assign hit       = wr_en && dev_match;
   assign fc_sel    = hit && (idx == '0);

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sel
         assign port_sel[p] = hit && (idx == IDX_W'(p + 1));
      end
   endgenerate
endmodule

// File: rtl/bsw_bank.sv
module bsw_bank #(
   parameter int DATA_W    = 8,
   parameter int NUM_PORTS = 2,
   parameter int FC_RST    = 16,
   parameter int PORT_RST  = 0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic                        fc_sel,
   input  logic [NUM_PORTS-1:0]        port_sel,
   input  logic [DATA_W-1:0]           wdata,
   output logic [DATA_W-1:0]           fc_q,
   output logic [NUM_PORTS*DATA_W-1:0] ports_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fc_q <= DATA_W'(FC_RST);
      end else if (we && fc_sel) begin
         fc_q <= wdata;
      end
   end

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ports_q[p*DATA_W +: DATA_W] <= DATA_W'(PORT_RST);
            end else if (we && port_sel[p]) begin
               ports_q[p*DATA_W +: DATA_W] <= wdata;
            end
         end
      end
   endgenerate

   // R4
   bank_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && fc_sel) |=> (fc_q == $past(wdata)));
endmodule

// File: rtl/bsw_switch.sv
module bsw_switch (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           trig,
   input  logic           frame_edge,
   input  logic           ssp,
   input  logic           multi_span,
   output bsw_pkg::bank_t active,
   output logic           pending
);
   logic apply;

   assign apply = pending && frame_edge && (ssp || !multi_span);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= bsw_pkg::BANK_A;
         pending <= 1'b0;
      end else if (apply) begin
         active  <= bsw_pkg::bank_t'(~active);
         pending <= 1'b0;
      end else if (trig) begin
         pending <= 1'b1;
      end
   end

   // R7
   flip_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active != $past(active)) |-> ($past(pending) && $past(frame_edge)));

   // R9
   flip_on_ssp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((active != $past(active)) && $past(multi_span)) |-> $past(ssp));

   // R6
   arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !pending) |=> (pending && $stable(active)));

   // R10
   ssp_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && ssp && !frame_edge) |=> (pending && $stable(active)));

   // R7
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pending) |-> (active != $past(active)));
endmodule

// File: rtl/bank_switch_ctrl.sv
module bank_switch_ctrl #(
   parameter int NUM_PORTS = 2,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 5,
   parameter int DEV_W     = 4,
   parameter int DEV_ID    = 3,
   parameter int FC_RST    = 16,
   parameter int PORT_RST  = 0,
   parameter int MULTI_BIT = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [DEV_W-1:0]            wr_dev,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic                        frame_edge,
   input  logic                        ssp,
   output logic                        active_bank,
   output logic                        switch_pending,
   output logic [DATA_W-1:0]           frame_ctl_o,
   output logic [NUM_PORTS*DATA_W-1:0] port_cfg_o
);
   localparam int PCFG_W = NUM_PORTS * DATA_W;
   localparam int IDX_W  = ADDR_W - 1;

   generate
      if (NUM_PORTS < 1 || NUM_PORTS + 1 > (1 << IDX_W)) begin : g_bad_ports
         $error("NUM_PORTS does not fit the register index field");
      end
      if (MULTI_BIT >= DATA_W) begin : g_bad_bit
         $error("MULTI_BIT outside the port word");
      end
      if (DEV_W < 4) begin : g_bad_dev
         $error("device address too narrow for the alias");
      end
   endgenerate

   logic                 hit;
   bsw_pkg::bank_t       wbank;
   bsw_pkg::bank_t       act;
   logic                 fc_sel;
   logic [NUM_PORTS-1:0] port_sel;
   logic [1:0]           bank_we;
   logic [DATA_W-1:0]    fc_q    [2];
   logic [PCFG_W-1:0]    ports_q [2];
   logic [NUM_PORTS-1:0] multi;
   logic                 trig;

   bsw_decode #(
      .DEV_W(DEV_W), .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS),
      .DEV_ID(DEV_ID), .ALIAS_ID(bsw_pkg::ALIAS_DEV)
   ) u_dec (
      .wr_en(wr_en), .wr_dev(wr_dev), .wr_addr(wr_addr),
      .hit(hit), .wbank(wbank), .fc_sel(fc_sel), .port_sel(port_sel)
   );

   generate
      for (genvar b = 0; b < 2; b++) begin : g_bank
         assign bank_we[b] = hit && (wbank == bsw_pkg::bank_t'(b));
         bsw_bank #(
            .DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS),
            .FC_RST(FC_RST), .PORT_RST(PORT_RST)
         ) u_bank (
            .clk(clk), .rst_n(rst_n), .we(bank_we[b]),
            .fc_sel(fc_sel), .port_sel(port_sel), .wdata(wr_data),
            .fc_q(fc_q[b]), .ports_q(ports_q[b])
         );
      end
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_multi
         assign multi[p] = port_cfg_o[p*DATA_W + MULTI_BIT];
      end
   endgenerate

   assign trig = fc_sel && (wbank != act);

   bsw_switch u_sw (
      .clk(clk), .rst_n(rst_n), .trig(trig), .frame_edge(frame_edge),
      .ssp(ssp), .multi_span(|multi), .active(act), .pending(switch_pending)
   );

   assign active_bank = act;
   assign frame_ctl_o = (act == bsw_pkg::BANK_B) ? fc_q[1] : fc_q[0];
   assign port_cfg_o  = (act == bsw_pkg::BANK_B) ? ports_q[1] : ports_q[0];

   // R5
   idle_bank_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && (wbank != act) && !switch_pending)
      |=> ($stable(frame_ctl_o) && $stable(port_cfg_o)));

   // R8
   own_fc_no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_sel && (wbank == act) && !switch_pending) |=> !switch_pending);

   // R3
   foreign_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !switch_pending) |=> ($stable(frame_ctl_o) && $stable(port_cfg_o)));
endmodule

// File: tb/bank_switch_ctrl_test.sv
module bank_switch_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_dev = '0;
   logic [4:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        frame_edge = 1'b0;
   logic        ssp = 1'b0;
   logic        active_bank;
   logic        switch_pending;
   logic [7:0]  frame_ctl_o;
   logic [15:0] port_cfg_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   bank_switch_ctrl uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dev(wr_dev),
      .wr_addr(wr_addr), .wr_data(wr_data), .frame_edge(frame_edge),
      .ssp(ssp), .active_bank(active_bank), .switch_pending(switch_pending),
      .frame_ctl_o(frame_ctl_o), .port_cfg_o(port_cfg_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] dev, input logic bank, input logic [3:0] idx,
                     input logic [7:0] data, input logic fe);
      @(negedge clk);
      wr_en = 1'b1; wr_dev = dev; wr_addr = {bank, idx}; wr_data = data; frame_edge = fe;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; frame_edge = 1'b0;
   endtask

   task automatic strobe(input logic fe, input logic s);
      @(negedge clk);
      frame_edge = fe; ssp = s;
      @(posedge clk);
      @(negedge clk);
      frame_edge = 1'b0; ssp = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 bank", active_bank, 0);
      chk("R1 pending", switch_pending, 0);
      chk("R1 fc", frame_ctl_o, 8'h10);
      chk("R1 ports", port_cfg_o, 16'h0000);
   endtask

   task automatic t_idle_write;
      wr(4'd3, 1'b1, 4'd1, 8'h5A, 1'b0);
      chk("R5 ports", port_cfg_o, 16'h0000);
      chk("R5 pending", switch_pending, 0);
   endtask

   task automatic t_active_write;
      wr(4'd3, 1'b0, 4'd2, 8'h31, 1'b0);
      chk("R4 port1", port_cfg_o, 16'h3100);
      wr(4'd3, 1'b0, 4'd5, 8'hFF, 1'b0);
      chk("R2 bad index ports", port_cfg_o, 16'h3100);
      chk("R2 bad index fc", frame_ctl_o, 8'h10);
   endtask

   task automatic t_own_fc;
      wr(4'd3, 1'b0, 4'd0, 8'h12, 1'b0);
      chk("R8 fc", frame_ctl_o, 8'h12);
      chk("R8 pending", switch_pending, 0);
      strobe(1'b1, 1'b1);
      chk("R8 bank", active_bank, 0);
   endtask

   task automatic t_dev;
      wr(4'd5, 1'b0, 4'd1, 8'h41, 1'b0);
      chk("R3 foreign", port_cfg_o, 16'h3100);
      wr(4'd15, 1'b0, 4'd1, 8'h41, 1'b0);
      chk("R3 alias", port_cfg_o, 16'h3141);
      wr(4'd5, 1'b1, 4'd0, 8'h77, 1'b0);
      chk("R3 foreign trigger", switch_pending, 0);
   endtask

   task automatic t_switch;
      wr(4'd3, 1'b1, 4'd2, 8'h09, 1'b0);
      wr(4'd15, 1'b1, 4'd0, 8'h20, 1'b1);
      chk("R6 pending", switch_pending, 1);
      chk("R7 no flip in write cycle", active_bank, 0);
      chk("R6 outputs", {frame_ctl_o, port_cfg_o}, {8'h12, 16'h3141});
      repeat (3) @(negedge clk);
      chk("R7 held", {active_bank, switch_pending}, 2'b01);
      strobe(1'b0, 1'b1);
      chk("R10 ssp alone", {active_bank, switch_pending}, 2'b01);
      strobe(1'b1, 1'b0);
      chk("R7 flipped", {active_bank, switch_pending}, 2'b10);
      chk("R7 new cfg", {frame_ctl_o, port_cfg_o}, {8'h20, 16'h095A});
   endtask

   task automatic t_multi;
      wr(4'd3, 1'b1, 4'd1, 8'h5E, 1'b0);
      chk("R4 multi set", port_cfg_o, 16'h095E);
      wr(4'd3, 1'b0, 4'd0, 8'h33, 1'b0);
      chk("R6 pending b0", switch_pending, 1);
      strobe(1'b1, 1'b0);
      chk("R9 wait ssp", {active_bank, switch_pending}, 2'b11);
      strobe(1'b0, 1'b1);
      chk("R10 ssp alone multi", {active_bank, switch_pending}, 2'b11);
      strobe(1'b1, 1'b1);
      chk("R9 flipped", {active_bank, switch_pending}, 2'b00);
      chk("R9 cfg", {frame_ctl_o, port_cfg_o}, {8'h33, 16'h3141});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle_write();
      t_active_write();
      t_own_fc();
      t_dev();
      t_switch();
      t_multi();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end
endmodule